// File: doc/BRIEF.md
# Flow-Controlled Serial Transmitter with Line-Driver Enable

This block turns bytes offered on a valid/ready handshake into asynchronous serial frames on a single output line. Before each frame it consults a clear-to-send input, so a receiver that cannot take more data can stop the flow. The decision is made only in the clock that would launch a start bit. A frame that has begun is always finished, and a byte that has been refused waits inside the block until the input returns high. It is never dropped and never partly sent.

For a shared two-wire half-duplex bus the block also drives a transmitter enable. The enable rises one bit time before the first start bit and stays on across back-to-back frames and across any wait for clear-to-send. It drops one bit time after the final stop bit has left the line, and only if no further byte was accepted during that trailing bit time. The bit time is `baud_div_i + 1` clock cycles. Parity is chosen per byte.

Top module: `uart_cts_tx`

## Requirements
- R1: While `rst_ni` is low and just after it is released, `tx_o` is 1, `de_o` is 0 and `ready_o` is 1.
- R2: A frame on `tx_o` is one 0 start bit, eight data bits with the LSB first, then an optional parity bit, then one 1 stop bit. Each bit lasts `baud_div_i + 1` clock cycles. `par_mode_i` is sampled when the byte is accepted: 0 or 3 means no parity bit, 1 means even parity, 2 means odd parity.
- R3: `cts_i` passes through two flip-flops. When `cts_i` rises while a byte waits, the start bit appears on `tx_o` after the third rising clock edge.
- R4: A byte accepted while the synchronized CTS is low is held. `tx_o` stays 1, `ready_o` stays 0 and `de_o` stays 1 until CTS returns, and then the byte is sent.
- R5: If CTS falls during a frame, that frame still completes through its stop bit. Any next byte then waits for CTS.
- R6: While CTS stays high, a byte accepted during the trailing bit time is launched without the enable dropping, so frames follow one another.
- R7: `ready_o` is high only when the block is idle or in the trailing bit time after a stop bit. It goes low on the edge that accepts a byte and stays low until that byte's stop bit ends.
- R8: `de_o` rises on the edge that accepts a byte from idle. The start bit cannot begin before `baud_div_i + 1` cycles later, and `de_o` is high whenever `tx_o` is 0.
- R9: `de_o` falls exactly `baud_div_i + 1` cycles after the last stop bit ends, provided no byte was accepted in that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_div_i | input | DIV_W | Bit time minus one, in clocks (at least 1) |
| par_mode_i | input | 2 | Parity select: 0/3 none, 1 even, 2 odd |
| data_i | input | DATA_W | Byte to send |
| valid_i | input | 1 | Byte offered |
| ready_o | output | 1 | Byte accepted on an edge where valid and ready are both high |
| cts_i | input | 1 | Clear to send, asynchronous |
| tx_o | output | 1 | Serial line, idle high |
| de_o | output | 1 | Half-duplex line driver enable |

## Verification
Several properties are checked on every cycle:
- the two-cycle CTS synchronizer latency;
- that a launch only follows a high synchronized CTS;
- that the line is only low while the driver is enabled and the input is not ready;
- that `ready_o` only falls after an offer;
- that the enable only falls out of an idle trailing bit with no offer.

Other properties can only be shown by the bench's scenarios:
- exact bit widths and parity values;
- that a byte is held across a long CTS-low interval;
- completion of a frame when CTS drops mid-character;
- the exact lead and trailing enable times.

These are covered by a clock-by-clock reference model that is compared against all three outputs.

// File: rtl/uart_cts_tx_pkg.sv
package uart_cts_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_HOLD, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_TAIL
  } tx_state_e;

  localparam logic [1:0] PAR_NONE = 2'd0;
  localparam logic [1:0] PAR_EVEN = 2'd1;
  localparam logic [1:0] PAR_ODD  = 2'd2;
endpackage

// File: rtl/uart_baud_tick.sv
module uart_baud_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= div_i;
    else if (cnt_q == '0) cnt_q <= div_i;
    else                  cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/uart_cts_sync.sv
module uart_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] ff_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q[0] <= 1'b0;
        else         ff_q[0] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q[g] <= 1'b0;
        else         ff_q[g] <= ff_q[g-1];
      end
    end
  end

  assign sync_o = ff_q[STAGES-1];
endmodule

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
  import uart_cts_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cts_i,
  input  logic [1:0]        par_mode_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              load_o,
  output logic              tx_o,
  output logic              active_o,
  output tx_state_e         state_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  tx_state_e         st_q, st_d;
  logic [DATA_W-1:0] sh_q;
  logic [IDX_W-1:0]  idx_q;
  logic              par_bit_q, par_en_q;
  logic              accept;

  assign ready_o  = (st_q == ST_IDLE) || (st_q == ST_TAIL);
  assign accept   = ready_o && valid_i;
  assign active_o = (st_q != ST_IDLE);
  assign state_o  = st_q;

  always_comb begin
    st_d   = st_q;
    load_o = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (valid_i) begin st_d = ST_LEAD; load_o = 1'b1; end
      ST_LEAD:  if (tick_i) st_d = ST_HOLD;
      // go/no-go taken only here, in the launch clock
      ST_HOLD:  if (cts_i) begin st_d = ST_START; load_o = 1'b1; end
      ST_START: if (tick_i) st_d = ST_DATA;
      ST_DATA:  if (tick_i && idx_q == LAST_IDX) st_d = par_en_q ? ST_PAR : ST_STOP;
      ST_PAR:   if (tick_i) st_d = ST_STOP;
      ST_STOP:  if (tick_i) st_d = ST_TAIL;
      ST_TAIL:  if (valid_i) st_d = ST_HOLD;
                else if (tick_i) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      sh_q      <= '0;
      idx_q     <= '0;
      par_bit_q <= 1'b0;
      par_en_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        sh_q      <= data_i;
        par_en_q  <= (par_mode_i == PAR_EVEN) || (par_mode_i == PAR_ODD);
        par_bit_q <= (^data_i) ^ (par_mode_i == PAR_ODD);
      end else if (st_q == ST_DATA && tick_i) begin
        sh_q  <= sh_q >> 1;
        idx_q <= idx_q + 1'b1;
      end
      if (st_q == ST_START) idx_q <= '0;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_START: tx_o = 1'b0;
      ST_DATA:  tx_o = sh_q[0];
      ST_PAR:   tx_o = par_bit_q;
      default:  tx_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/uart_cts_tx.sv
module uart_cts_tx
  import uart_cts_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16,
  parameter bit GEN_DE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  baud_div_i,
  input  logic [1:0]        par_mode_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic              cts_i,
  output logic              tx_o,
  output logic              de_o
);
  logic      tick, load, cts_sync, active;
  tx_state_e tx_state;

  uart_cts_sync #(.STAGES(2)) u_sync (
    .clk_i, .rst_ni, .async_i(cts_i), .sync_o(cts_sync)
  );

  uart_baud_tick #(.DIV_W(DIV_W)) u_baud (
    .clk_i, .rst_ni, .load_i(load), .div_i(baud_div_i), .tick_o(tick)
  );

  uart_tx_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk_i, .rst_ni,
    .tick_i(tick), .cts_i(cts_sync), .par_mode_i, .data_i, .valid_i,
    .ready_o, .load_o(load), .tx_o, .active_o(active), .state_o(tx_state)
  );

  if (GEN_DE) begin : g_de
    assign de_o = active;
  end else begin : g_no_de
    assign de_o = 1'b0;
  end
endmodule

// File: rtl/uart_cts_tx_chk.sv
module uart_cts_tx_chk
  import uart_cts_tx_pkg::*;
#(
  parameter bit GEN_DE = 1'b1
) (
  input logic      clk_i,
  input logic      rst_ni,
  input logic      cts_i,
  input logic      cts_sync,
  input tx_state_e tx_state,
  input logic      valid_i,
  input logic      ready_o,
  input logic      tx_o,
  input logic      de_o
);
  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cyc_q <= '0;
    else if (cyc_q != 3) cyc_q <= cyc_q + 1'b1;
  end

  a_r3_sync_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2) |-> (cts_sync == $past(cts_i, 2)));

  a_r4_launch_needs_cts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_state == ST_START && $past(tx_state) == ST_HOLD) |-> $past(cts_sync));

  a_r7_busy_while_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_o |-> !ready_o);

  a_r7_ready_falls_on_offer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> $past(valid_i));

  if (GEN_DE) begin : g_de_chk
    a_r8_de_covers_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tx_o |-> de_o);

    a_r9_de_release_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(de_o) |-> ($past(ready_o) && $past(tx_o) && !$past(valid_i)));
  end
endmodule

bind uart_cts_tx uart_cts_tx_chk #(.GEN_DE(GEN_DE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cts_i(cts_i), .cts_sync(cts_sync),
  .tx_state(tx_state), .valid_i(valid_i), .ready_o(ready_o),
  .tx_o(tx_o), .de_o(de_o)
);

// File: tb/uart_cts_tx_tb_top.sv
module uart_cts_tx_tb_top;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [DIV_W-1:0]  div = 16'd3;
  logic [1:0]        par = 2'd0;
  logic [DATA_W-1:0] data = '0;
  logic              valid = 1'b0;
  logic              cts = 1'b0;
  logic              ready, tx, de;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  uart_cts_tx #(.DATA_W(DATA_W), .DIV_W(DIV_W), .GEN_DE(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .baud_div_i(div), .par_mode_i(par),
    .data_i(data), .valid_i(valid), .ready_o(ready), .cts_i(cts),
    .tx_o(tx), .de_o(de)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 idle,1 lead,2 hold,3 frame,4 tail
  int     m_ph, m_cnt;
  bit     m_s1, m_s2;
  logic [7:0] m_data;
  logic [1:0] m_par;
  bit     line_q[$];

  task automatic build_frame();
    bit bits[$];
    bits.push_back(1'b0);
    for (int i = 0; i < 8; i++) bits.push_back(m_data[i]);
    if (m_par == 2'd1) bits.push_back(^m_data);
    if (m_par == 2'd2) bits.push_back(~^m_data);
    bits.push_back(1'b1);
    foreach (bits[k])
      for (int r = 0; r <= int'(div); r++) line_q.push_back(bits[k]);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_s1 = 0; m_s2 = 0; line_q.delete();
    end else begin
      bit go;
      go = m_s2; m_s2 = m_s1; m_s1 = cts;
      case (m_ph)
        0: if (valid) begin m_data = data; m_par = par; m_ph = 1; m_cnt = int'(div); end
        1: if (m_cnt == 0) m_ph = 2; else m_cnt--;
        2: if (go) begin build_frame(); m_ph = 3; end
        3: begin
             void'(line_q.pop_front());
             if (line_q.size() == 0) begin m_ph = 4; m_cnt = int'(div); end
           end
        default: if (valid) begin m_data = data; m_par = par; m_ph = 2; end
                 else if (m_cnt == 0) m_ph = 0; else m_cnt--;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit etx;
      etx = (m_ph == 3) ? line_q[0] : 1'b1;
      check(tx == etx, "R2 R5 tx_o", tx, etx);
      check(de == (m_ph != 0), "R8 R9 de_o", de, m_ph != 0);
      check(ready == (m_ph == 0 || m_ph == 4), "R7 ready_o", ready, m_ph == 0 || m_ph == 4);
    end
  end

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    data = b; valid = 1'b1;
    while (!ready) @(negedge clk);
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (de || !ready);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(tx == 1'b1, "R1 tx_o in reset", tx, 1);
    check(de == 1'b0, "R1 de_o in reset", de, 0);
    check(ready == 1'b1, "R1 ready_o in reset", ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx && !de && ready, "R1 after release", {tx, de, ready}, 3'b101);
    cts = 1'b1;
    repeat (3) @(negedge clk);

    // R2 R6 back-to-back, no parity
    send(8'hA5);
    send(8'h3C);
    check(de && !ready, "R6 second byte queued, enable held", {de, ready}, 2'b10);
    wait_idle();
    check(!de, "R9 enable released", de, 0);

    // R2 even and odd parity, shorter bit
    div = 16'd2;
    par = 2'd1; send(8'h07);
    par = 2'd2; send(8'h07);
    par = 2'd3; send(8'h81);
    wait_idle();

    // R2 minimum bit time
    div = 16'd1; par = 2'd2;
    send(8'h00);
    wait_idle();

    // R4 hold while CTS low, R3 latency on release
    div = 16'd3; par = 2'd0;
    cts = 1'b0;
    send(8'h5A);
    repeat (50) @(negedge clk);
    check(tx && !ready && de, "R4 byte held", {tx, ready, de}, 3'b101);
    cts = 1'b1;
    @(negedge clk); check(tx == 1'b1, "R3 no launch after 1 edge", tx, 1);
    @(negedge clk); check(tx == 1'b1, "R3 no launch after 2 edges", tx, 1);
    @(negedge clk); check(tx == 1'b0, "R3 start after 3 edges", tx, 0);
    wait_idle();

    // R5 CTS withdrawn mid-frame
    div = 16'd4; par = 2'd1;
    send(8'h81);
    repeat (20) @(negedge clk);
    cts = 1'b0;
    send(8'h42);
    repeat (80) @(negedge clk);
    check(tx && !ready && de, "R5 next byte waits after completed frame", {tx, ready, de}, 3'b101);
    cts = 1'b1;
    wait_idle();
    repeat (5) @(negedge clk);
    check(tx && !de && ready, "R9 idle at end", {tx, de, ready}, 3'b101);
    finish_run();
  end
endmodule